// File: doc/BRIEF.md
# Low-speed USB NRZI packet transmitter

This block puts one packet on a low-speed USB line pair. A single-cycle start pulse, together with a byte count, begins a transfer. The block then enables its drivers and holds the idle J state for one bit period. Next it sends the sync pattern. After the sync pattern it sends as many packet bytes as the count asks for, and it fetches each byte from an upstream buffer through a request pulse. Every bit goes out least significant bit first, with NRZI coding. A stuffed bit is added after any run of six ones. The block ends the packet with a timed end-of-packet, which is two bit periods of SE0 and then one bit period of J. After that it releases the drivers and pulses a done flag.

Each bit period lasts `BIT_CLKS` clocks. The byte source gets at least one full bit period of notice before it must present the next byte, so the bytes follow each other on the line with no gap. The block does not generate CRC: the caller places any CRC bytes in the buffer.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset, oe_o, busy_o, done_o and byte_req_o are low, and the lines rest at J (dp_o=0, dm_o=1).
- R2: When start_i is high while the block is idle, oe_o and busy_o rise on the next clock. The lines then hold J for exactly `BIT_CLKS` cycles.
- R3: The first byte on the line is the sync value 0x80, sent least significant bit first. The line therefore shows K,J,K,J,K,J,K,K, one bit period per symbol.
- R4: J is dp_o=0/dm_o=1 and K is dp_o=1/dm_o=0. A 0 bit toggles the line state and a 1 bit keeps it. The lines change only at bit-period boundaries.
- R5: After six consecutive 1 bits, the block inserts one extra bit period that toggles the line, and the run count restarts at zero. The run count continues across byte boundaries, including the last bit of the sync byte. The rule also applies after the final data bit.
- R6: Exactly len_i bytes follow the sync byte, each least significant bit first, with no idle bit periods between bytes.
- R7: byte_req_o is a one-cycle pulse in the first cycle of bit 7 of every byte that has a following data byte. byte_data_i must hold the next byte from the cycle after that pulse until the current byte's last bit period (including any stuffed bit) ends.
- R8: After the last bit (or stuffed bit), both lines are low for 2×`BIT_CLKS` cycles, then J for `BIT_CLKS` cycles, and then oe_o falls.
- R9: busy_o is high exactly while oe_o is high. done_o is a one-cycle pulse in the first cycle after oe_o falls.
- R10: start_i is ignored while busy_o is high, and the packet in progress is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a packet (accepted when idle) |
| len_i | input | LEN_W | Number of data bytes after sync |
| byte_req_o | output | 1 | Request pulse for the next data byte |
| byte_data_i | input | 8 | Next data byte |
| dp_o | output | 1 | D+ line level |
| dm_o | output | 1 | D- line level |
| oe_o | output | 1 | Line driver enable |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse after bus release |

## Verification
The embedded assertions check the invariants that hold on every cycle. The line levels stay fixed inside a bit period, and the ones-run counter never passes six. A due stuff period always toggles the line. The request and done outputs are single-cycle pulses, and done follows a falling busy. The bit timer stays within its range, and the released line rests at J. Only the bench scenarios can show the actual waveform: the sync pattern, where stuffed bits fall across byte boundaries and at packet end, the byte order and request timing, the exact EOP lengths, and that a start during a transfer has no effect. The bench checks all of these against a behavioural slot-by-slot model.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_DATA,
    ST_SE0,
    ST_EOPJ
  } tx_state_e;
endpackage

// File: rtl/usb_ls_tx_baud.sv
module usb_ls_tx_baud #(
  parameter int BIT_CLKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = run_i && (cnt_q == LAST);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < BIT_CLKS); // R2
endmodule

// File: rtl/usb_ls_tx_nrzi.sv
module usb_ls_tx_nrzi #(
  parameter int RUN_LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic step_i,
  input  logic bit_i,
  output logic is_k_o,
  output logic stuff_due_o
);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic          k_q;
  logic [RW-1:0] run_q;

  assign stuff_due_o = (run_q == RW'(RUN_LEN));
  assign is_k_o      = k_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q   <= 1'b0;
      run_q <= '0;
    end else if (init_i) begin
      k_q   <= 1'b0;
      run_q <= '0;
    end else if (step_i) begin
      if (stuff_due_o || !bit_i) begin
        k_q   <= ~k_q;
        run_q <= '0;
      end else begin
        run_q <= run_q + RW'(1);
      end
    end
  end

  AST_RUN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(run_q) <= RUN_LEN); // R5
  AST_STUFF_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && stuff_due_o && !init_i) |=> (k_q != $past(k_q))); // R5
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usb_ls_tx_pkg::*;
#(
  parameter int BIT_CLKS = 8,
  parameter int LEN_W    = 8,
  parameter int RUN_LEN  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             byte_req_o,
  input  logic [7:0]       byte_data_i,
  output logic             dp_o,
  output logic             dm_o,
  output logic             oe_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [7:0] SYNC = 8'h80;

  tx_state_e        state_q;
  logic [7:0]       shift_q;
  logic [2:0]       bit_q;
  logic [LEN_W-1:0] left_q;
  logic             se0_2nd_q, req_q, done_q;

  logic tick, is_k, stuff_due, accept, last_bit, more, step, next_bit, run;

  assign run      = (state_q != ST_IDLE);
  assign accept   = (state_q == ST_IDLE) && start_i;
  assign last_bit = (bit_q == 3'd7);
  assign more     = (left_q != '0);
  assign step     = tick && ((state_q == ST_LEAD) ||
                    ((state_q == ST_DATA) && (stuff_due || !last_bit || more)));

  always_comb begin
    if (state_q == ST_LEAD) next_bit = SYNC[0];
    else if (last_bit)      next_bit = byte_data_i[0];
    else                    next_bit = shift_q[1];
  end

  usb_ls_tx_baud #(.BIT_CLKS(BIT_CLKS)) u_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  usb_ls_tx_nrzi #(.RUN_LEN(RUN_LEN)) u_nrzi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (accept),
    .step_i     (step),
    .bit_i      (next_bit),
    .is_k_o     (is_k),
    .stuff_due_o(stuff_due)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      shift_q   <= '0;
      bit_q     <= '0;
      left_q    <= '0;
      se0_2nd_q <= 1'b0;
      req_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LEAD;
          left_q  <= len_i;
        end
        ST_LEAD: if (tick) begin
          state_q <= ST_DATA;
          shift_q <= SYNC;
          bit_q   <= '0;
        end
        ST_DATA: if (tick && !stuff_due) begin
          if (!last_bit) begin
            shift_q <= {1'b0, shift_q[7:1]};
            bit_q   <= bit_q + 3'd1;
            req_q   <= (bit_q == 3'd6) && more;
          end else if (more) begin
            shift_q <= byte_data_i;
            bit_q   <= '0;
            left_q  <= left_q - LEN_W'(1);
          end else begin
            state_q   <= ST_SE0;
            se0_2nd_q <= 1'b0;
          end
        end
        ST_SE0: if (tick) begin
          if (se0_2nd_q) state_q <= ST_EOPJ;
          else           se0_2nd_q <= 1'b1;
        end
        ST_EOPJ: if (tick) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_LEAD, ST_DATA: begin dp_o = is_k; dm_o = ~is_k; end
      ST_SE0:           begin dp_o = 1'b0; dm_o = 1'b0;  end
      default:          begin dp_o = 1'b0; dm_o = 1'b1;  end
    endcase
  end

  assign oe_o       = run;
  assign busy_o     = run;
  assign done_o     = done_q;
  assign byte_req_o = req_q;

  AST_LINES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !tick) |=> ($stable(dp_o) && $stable(dm_o))); // R4
  AST_REST_J: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (!dp_o && dm_o)); // R1
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_req_o |=> !byte_req_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R9
endmodule

// File: tb/usb_ls_tx_bench.sv
`timescale 1ns/1ps
module usb_ls_tx_bench;
  localparam int BIT = 4;

  logic       clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [7:0] len_i = '0, byte_data_i = '0;
  logic       byte_req_o, dp_o, dm_o, oe_o, busy_o, done_o;

  int total = 0, bad = 0;
  logic [5:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] pkt_q[$];
  logic       k;
  int         run;

  always #10 clk_i = ~clk_i;

  usb_ls_tx #(.BIT_CLKS(BIT), .LEN_W(8), .RUN_LEN(6)) u_usb_ls_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .len_i(len_i),
    .byte_req_o(byte_req_o), .byte_data_i(byte_data_i),
    .dp_o(dp_o), .dm_o(dm_o), .oe_o(oe_o), .busy_o(busy_o), .done_o(done_o)
  );

  // vector: {dp, dm, oe, busy, done, req}
  task automatic check(input logic [5:0] e, input string tag);
    logic [5:0] a;
    a = {dp_o, dm_o, oe_o, busy_o, done_o, byte_req_o};
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b (dp dm oe busy done req)",
               (a[5:1] == e[5:1]) ? "R7" : tag, a, e);
    end
  endtask

  task automatic push_slot(input logic dp, input logic dm, input logic req, input string tag);
    for (int c = 0; c < BIT; c++) begin
      exp_q.push_back({dp, dm, 1'b1, 1'b1, 1'b0, req && (c == 0)});
      tag_q.push_back(tag);
    end
  endtask

  task automatic emit(input logic b, input logic req, input string tag);
    if (!b) begin k = ~k; run = 0; end
    else run++;
    push_slot(k, ~k, req, tag);
    if (run == 6) begin
      k = ~k; run = 0;
      push_slot(k, ~k, 1'b0, "R5");
    end
  endtask

  task automatic build();
    int n;
    n = pkt_q.size();
    exp_q.delete(); tag_q.delete();
    k = 1'b0; run = 0;
    push_slot(1'b0, 1'b1, 1'b0, "R2");
    for (int i = 0; i < 8; i++) emit(((8'h80 >> i) & 8'h1) != 0, (i == 7) && (n > 0), "R3");
    for (int j = 0; j < n; j++)
      for (int i = 0; i < 8; i++) emit(pkt_q[j][i], (i == 7) && (j < n - 1), "R6");
    push_slot(1'b0, 1'b0, 1'b0, "R8");
    push_slot(1'b0, 1'b0, 1'b0, "R8");
    push_slot(1'b0, 1'b1, 1'b0, "R8");
    exp_q.push_back(6'b010010); tag_q.push_back("R9");
    exp_q.push_back(6'b010000); tag_q.push_back("R9");
  endtask

  task automatic send(input int mid_start);
    int idx;
    build();
    idx = 0;
    len_i   = 8'(pkt_q.size());
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int e = 0; e < exp_q.size(); e++) begin
      check(exp_q[e], (mid_start > 0 && e > mid_start) ? "R10" : tag_q[e]);
      if (byte_req_o && idx < pkt_q.size()) begin
        byte_data_i = pkt_q[idx];
        idx++;
      end
      start_i = (mid_start > 0 && e == mid_start);
      @(negedge clk_i);
    end
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(6'b010000, "R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(6'b010000, "R1");

    pkt_q = {};                              send(0); // R3 sync only
    pkt_q = {8'h00};                         send(0); // R4 all toggles
    pkt_q = {8'hFF, 8'hFF};                  send(0); // R5 across bytes
    pkt_q = {8'hFC};                         send(0); // R5 stuff after last bit
    pkt_q = {8'hA5, 8'h7E, 8'hFF, 8'h01};    send(0); // R6 R7
    pkt_q = {8'h3C, 8'hC3};                  send(20); // R10 start while busy
    pkt_q = {8'h3F, 8'h80, 8'h00};           send(0); // R5 R8

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule